// File: doc/BRIEF.md
# Dual-Issue Dependency Stall Unit

This block sits beside a two-wide, in-order, single-cycle core that fetches an instruction pair every cycle. It takes the decoded class, register numbers and effective data-memory addresses of both slots. It decides whether the younger instruction (slot 2) can retire in the same cycle as the older one (slot 1). When it cannot, the block raises a stall and forces slot 2's register-write and memory-write enables low, so slot 2 changes no architectural state.

The block also owns the fetch program counter. On a stall the counter moves forward by a single instruction, so the squashed slot-2 instruction is fetched again as the next slot 1. Without a stall the counter moves forward by a full pair. A taken control transfer from slot 1 loads the supplied target instead, and a halt in slot 1 freezes the counter. Forwarding, speculation and the register file itself belong to other blocks.

Top module: `dual_issue_stall`

## Requirements
- R1: The slot class is a 3-bit code: 0 other, 1 jump (direct, linking, or through a register), 2 conditional branch, 3 load, 4 store, 5 halt. If slot 1 has class 1, `stall_o` is 1 whatever slot 2 holds.
- R2: If slot 1 has class 2, `stall_o` is 1 whatever slot 2 holds.
- R3: If slot 1 has class 5, `stall_o` is 1 and `pc_o` keeps its value at the next clock edge.
- R4: `stall_o` is 1 when one slot is a load and the other is a store and their word addresses (address bits [AW-1:2]) are equal, in either order. Accesses to different words, and two stores or two loads, do not stall on this rule.
- R5: `stall_o` is 1 when slot 1 writes a register (`s1_reg_we_i`=1) and slot 2 reads that register through an enabled source port (`s2_src_a_use_i`/`s2_src_b_use_i`).
- R6: `stall_o` is 1 when slot 2 writes a register that slot 1 reads through an enabled source port.
- R7: A destination of register 0, or a destination whose write enable is 0, never causes a stall under R5 or R6. The same holds for a source whose use bit is 0.
- R8: While `stall_o` is 1, `s2_reg_we_o` and `s2_mem_we_o` are 0. While it is 0, they equal `s2_reg_we_i` and `s2_mem_we_i`.
- R9: At each clock edge with no halt in slot 1, `pc_o` becomes `redirect_pc_i` if `redirect_i` is 1. Otherwise it becomes `pc_o`+4 when stalled and `pc_o`+8 when not.
- R10: While `rst_ni` is 0, `pc_o` equals the RESET_PC parameter (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s1_kind_i | input | 3 | Slot 1 class code |
| s1_rd_i | input | RW | Slot 1 destination register |
| s1_reg_we_i | input | 1 | Slot 1 writes its destination |
| s1_src_a_i | input | RW | Slot 1 first source register |
| s1_src_a_use_i | input | 1 | Slot 1 reads first source |
| s1_src_b_i | input | RW | Slot 1 second source register |
| s1_src_b_use_i | input | 1 | Slot 1 reads second source |
| s1_addr_i | input | AW | Slot 1 data-memory address |
| s2_kind_i | input | 3 | Slot 2 class code |
| s2_rd_i | input | RW | Slot 2 destination register |
| s2_reg_we_i | input | 1 | Slot 2 register-write enable from its decoder |
| s2_mem_we_i | input | 1 | Slot 2 memory-write enable from its decoder |
| s2_src_a_i | input | RW | Slot 2 first source register |
| s2_src_a_use_i | input | 1 | Slot 2 reads first source |
| s2_src_b_i | input | RW | Slot 2 second source register |
| s2_src_b_use_i | input | 1 | Slot 2 reads second source |
| s2_addr_i | input | AW | Slot 2 data-memory address |
| redirect_i | input | 1 | Slot 1 control transfer is taken |
| redirect_pc_i | input | PW | Target of the taken transfer |
| stall_o | output | 1 | Slot 2 must not retire this cycle |
| s2_reg_we_o | output | 1 | Gated slot 2 register-write enable |
| s2_mem_we_o | output | 1 | Gated slot 2 memory-write enable |
| pc_o | output | PW | Fetch address of the current pair |

## Verification
The bench puts small register numbers and a few nearby addresses on both slots, so that register 0, disabled write enables, unused sources and byte offsets inside a single word meet often. A design that skips the reverse slot-2-to-slot-1 check, treats register 0 as a producer, or compares byte addresses instead of word addresses would report a stall flag that differs from the model's. A store/store pair sent into the load/store rule would show up the same way. A design that advances by the pair width on a stall, or moves past a halt, would have its program counter drift away from the model's.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int unsigned KIND_W = 3;
  typedef enum logic [KIND_W-1:0] {
    K_OTHER  = 3'd0,
    K_JUMP   = 3'd1,
    K_BRANCH = 3'd2,
    K_LOAD   = 3'd3,
    K_STORE  = 3'd4,
    K_HALT   = 3'd5
  } kind_e;

  typedef struct packed {
    logic [4:0] rd;
    logic       we;
  } prod_t;
endpackage

// File: rtl/dis_reg_dep.sv
// one direction: does producer's destination feed either consumer source
module dis_reg_dep #(
  parameter int unsigned RW = 5
) (
  input  logic [RW-1:0] prod_rd_i,
  input  logic          prod_we_i,
  input  logic [RW-1:0] src_a_i,
  input  logic          src_a_use_i,
  input  logic [RW-1:0] src_b_i,
  input  logic          src_b_use_i,
  output logic          hit_o
);
  logic live;
  assign live  = prod_we_i && (prod_rd_i != '0);
  assign hit_o = live && ((src_a_use_i && src_a_i == prod_rd_i) ||
                          (src_b_use_i && src_b_i == prod_rd_i));
endmodule

// File: rtl/dis_mem_conflict.sv
module dis_mem_conflict #(
  parameter int unsigned AW = 32
) (
  input  logic [2:0]    kind1_i,
  input  logic [2:0]    kind2_i,
  input  logic [AW-1:0] addr1_i,
  input  logic [AW-1:0] addr2_i,
  output logic          conflict_o
);
  import dis_pkg::*;
  localparam int unsigned WA = AW - 2;
  logic same_word, ld_st, st_ld;
  assign same_word  = addr1_i[AW-1:2] == addr2_i[AW-1:2];
  assign ld_st      = (kind1_i == K_LOAD)  && (kind2_i == K_STORE);
  assign st_ld      = (kind1_i == K_STORE) && (kind2_i == K_LOAD);
  assign conflict_o = same_word && (ld_st || st_ld);
  logic [WA-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/dis_pc_unit.sv
module dis_pc_unit #(
  parameter int unsigned         PW       = 32,
  parameter logic [PW-1:0]       RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          halt_i,
  input  logic          redirect_i,
  input  logic [PW-1:0] target_i,
  input  logic          stall_i,
  output logic [PW-1:0] pc_o
);
  localparam logic [PW-1:0] STEP1 = PW'(4);
  localparam logic [PW-1:0] STEP2 = PW'(8);
  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    if (halt_i)          pc_d = pc_q;
    else if (redirect_i) pc_d = target_i;
    else if (stall_i)    pc_d = pc_q + STEP1;
    else                 pc_d = pc_q + STEP2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  p_halt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> pc_q == $past(pc_q));
  p_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_i && !redirect_i) |=> pc_q == $past(pc_q) + ($past(stall_i) ? STEP1 : STEP2));
  p_redirect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_i && redirect_i) |=> pc_q == $past(target_i));
endmodule

// File: rtl/dual_issue_stall.sv
module dual_issue_stall #(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   RW       = 5,
  parameter int unsigned   PW       = 32,
  parameter logic [PW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    s1_kind_i,
  input  logic [RW-1:0] s1_rd_i,
  input  logic          s1_reg_we_i,
  input  logic [RW-1:0] s1_src_a_i,
  input  logic          s1_src_a_use_i,
  input  logic [RW-1:0] s1_src_b_i,
  input  logic          s1_src_b_use_i,
  input  logic [AW-1:0] s1_addr_i,
  input  logic [2:0]    s2_kind_i,
  input  logic [RW-1:0] s2_rd_i,
  input  logic          s2_reg_we_i,
  input  logic          s2_mem_we_i,
  input  logic [RW-1:0] s2_src_a_i,
  input  logic          s2_src_a_use_i,
  input  logic [RW-1:0] s2_src_b_i,
  input  logic          s2_src_b_use_i,
  input  logic [AW-1:0] s2_addr_i,
  input  logic          redirect_i,
  input  logic [PW-1:0] redirect_pc_i,
  output logic          stall_o,
  output logic          s2_reg_we_o,
  output logic          s2_mem_we_o,
  output logic [PW-1:0] pc_o
);
  import dis_pkg::*;
  localparam int unsigned NS = 2;

  logic [NS-1:0][RW-1:0] rd, sa, sb;
  logic [NS-1:0]         we, ua, ub, dep_hit;

  assign rd = {s2_rd_i, s1_rd_i};
  assign we = {s2_reg_we_i, s1_reg_we_i};
  assign sa = {s2_src_a_i, s1_src_a_i};
  assign ua = {s2_src_a_use_i, s1_src_a_use_i};
  assign sb = {s2_src_b_i, s1_src_b_i};
  assign ub = {s2_src_b_use_i, s1_src_b_use_i};

  // d=0: slot1 feeds slot2; d=1: slot2 feeds slot1
  for (genvar d = 0; d < NS; d++) begin : g_dep
    localparam int unsigned C = NS - 1 - d;
    dis_reg_dep #(.RW(RW)) u_dep (
      .prod_rd_i  (rd[d]),
      .prod_we_i  (we[d]),
      .src_a_i    (sa[C]),
      .src_a_use_i(ua[C]),
      .src_b_i    (sb[C]),
      .src_b_use_i(ub[C]),
      .hit_o      (dep_hit[d])
    );
  end

  logic mem_hit;
  dis_mem_conflict #(.AW(AW)) u_mem (
    .kind1_i   (s1_kind_i),
    .kind2_i   (s2_kind_i),
    .addr1_i   (s1_addr_i),
    .addr2_i   (s2_addr_i),
    .conflict_o(mem_hit)
  );

  logic ctrl_hit, halt1;
  assign halt1    = s1_kind_i == K_HALT;
  assign ctrl_hit = (s1_kind_i == K_JUMP) || (s1_kind_i == K_BRANCH) || halt1;
  assign stall_o  = ctrl_hit || mem_hit || (|dep_hit);

  assign s2_reg_we_o = s2_reg_we_i && !stall_o;
  assign s2_mem_we_o = s2_mem_we_i && !stall_o;

  dis_pc_unit #(.PW(PW), .RESET_PC(RESET_PC)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .halt_i    (halt1),
    .redirect_i(redirect_i),
    .target_i  (redirect_pc_i),
    .stall_i   (stall_o),
    .pc_o      (pc_o)
  );

  p_jump_stall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_kind_i == K_JUMP) |-> stall_o);
  p_branch_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_kind_i == K_BRANCH) |-> stall_o);
  p_zero_dst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_rd_i == '0) |-> !dep_hit[0]);
  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!s2_reg_we_o && !s2_mem_we_o));
  p_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |-> (s2_reg_we_o == s2_reg_we_i && s2_mem_we_o == s2_mem_we_i));
endmodule

// File: tb/dual_issue_stall_tb.sv
module dual_issue_stall_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, RW = 5, PW = 32;

  logic clk = 0, rst_ni = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0] k1, k2;
  logic [RW-1:0] rd1, rd2, a1, b1, a2, b2;
  logic we1, we2, mw2, ua1, ub1, ua2, ub2, redir;
  logic [AW-1:0] ad1, ad2;
  logic [PW-1:0] tgt;
  logic stall, rwe_o, mwe_o;
  logic [PW-1:0] pc;

  dual_issue_stall u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .s1_kind_i(k1), .s1_rd_i(rd1), .s1_reg_we_i(we1),
    .s1_src_a_i(a1), .s1_src_a_use_i(ua1), .s1_src_b_i(b1), .s1_src_b_use_i(ub1),
    .s1_addr_i(ad1),
    .s2_kind_i(k2), .s2_rd_i(rd2), .s2_reg_we_i(we2), .s2_mem_we_i(mw2),
    .s2_src_a_i(a2), .s2_src_a_use_i(ua2), .s2_src_b_i(b2), .s2_src_b_use_i(ub2),
    .s2_addr_i(ad2),
    .redirect_i(redir), .redirect_pc_i(tgt),
    .stall_o(stall), .s2_reg_we_o(rwe_o), .s2_mem_we_o(mwe_o), .pc_o(pc)
  );

  int total = 0, bad = 0;
  logic [PW-1:0] exp_pc;
  string why;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit reads(input logic [RW-1:0] r, input logic [RW-1:0] sa,
                               input logic ua_, input logic [RW-1:0] sb, input logic ub_);
    return (ua_ && sa == r) || (ub_ && sb == r);
  endfunction

  // reference: returns expected stall and a tag of the first rule that fires
  function automatic bit model(output string tag);
    bit lsx;
    tag = "R7";
    lsx = (ad1 >> 2) == (ad2 >> 2) && ((k1 == 3 && k2 == 4) || (k1 == 4 && k2 == 3));
    if (k1 == 1) begin tag = "R1"; return 1; end
    if (k1 == 2) begin tag = "R2"; return 1; end
    if (k1 == 5) begin tag = "R3"; return 1; end
    if (lsx)     begin tag = "R4"; return 1; end
    if (we1 && rd1 != 0 && reads(rd1, a2, ua2, b2, ub2)) begin tag = "R5"; return 1; end
    if (we2 && rd2 != 0 && reads(rd2, a1, ua1, b1, ub1)) begin tag = "R6"; return 1; end
    return 0;
  endfunction

  task automatic clear();
    k1 = 0; k2 = 0; rd1 = 0; rd2 = 0; a1 = 0; b1 = 0; a2 = 0; b2 = 0;
    we1 = 0; we2 = 0; mw2 = 0; ua1 = 0; ub1 = 0; ua2 = 0; ub2 = 0;
    redir = 0; ad1 = 0; ad2 = 0; tgt = 0;
  endtask

  // drive at negedge, check combinational outputs, predict next pc
  task automatic step();
    bit es;
    #1;
    es = model(why);
    chk(why, stall, es);
    chk("R8 reg_we", rwe_o, we2 && !es);
    chk("R8 mem_we", mwe_o, mw2 && !es);
    if (k1 == 5)    exp_pc = exp_pc;
    else if (redir) exp_pc = tgt;
    else            exp_pc = exp_pc + (es ? 4 : 8);
    @(negedge clk);
    chk(k1 == 5 ? "R3 pc" : "R9 pc", pc, exp_pc);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear();
    #(CLK_PERIOD * 2);
    chk("R10 reset pc", pc, 0);
    @(negedge clk); rst_ni = 1;
    exp_pc = 0;
    // R9 plain pair advance
    step();
    // R1 jump with redirect
    clear(); k1 = 1; redir = 1; tgt = 32'h100; we2 = 1; mw2 = 1; step();
    // R2 branch not taken
    clear(); k1 = 2; we2 = 1; step();
    // R3 halt freezes pc
    clear(); k1 = 5; step(); step();
    // R4 load then store, same word different byte
    clear(); k1 = 3; k2 = 4; ad1 = 32'h40; ad2 = 32'h43; mw2 = 1; step();
    // R4 store then load same word
    clear(); k1 = 4; k2 = 3; ad1 = 32'h80; ad2 = 32'h82; we2 = 1; step();
    // R4 negative: different words; store/store
    clear(); k1 = 3; k2 = 4; ad1 = 32'h40; ad2 = 32'h44; mw2 = 1; step();
    clear(); k1 = 4; k2 = 4; ad1 = 32'h40; ad2 = 32'h40; mw2 = 1; step();
    // R5 forward dependency on source b
    clear(); we1 = 1; rd1 = 7; b2 = 7; ub2 = 1; we2 = 1; step();
    // R6 reverse dependency
    clear(); we2 = 1; rd2 = 9; a1 = 9; ua1 = 1; step();
    // R7 register 0, write off, source unused
    clear(); we1 = 1; rd1 = 0; a2 = 0; ua2 = 1; we2 = 1; step();
    clear(); we1 = 0; rd1 = 3; a2 = 3; ua2 = 1; we2 = 1; step();
    clear(); we1 = 1; rd1 = 3; a2 = 3; ua2 = 0; we2 = 1; step();
    // mixed random patterns over small register and address spaces
    for (int i = 0; i < 3000; i++) begin
      k1 = 3'($urandom_range(0, 5)); k2 = 3'($urandom_range(0, 5));
      if (k1 == 5 && ($urandom_range(0, 3) != 0)) k1 = 0;
      rd1 = RW'($urandom_range(0, 3)); rd2 = RW'($urandom_range(0, 3));
      a1 = RW'($urandom_range(0, 3)); b1 = RW'($urandom_range(0, 3));
      a2 = RW'($urandom_range(0, 3)); b2 = RW'($urandom_range(0, 3));
      we1 = 1'($urandom); we2 = 1'($urandom); mw2 = 1'($urandom);
      ua1 = 1'($urandom); ub1 = 1'($urandom); ua2 = 1'($urandom); ub2 = 1'($urandom);
      ad1 = AW'($urandom_range(0, 11)); ad2 = AW'($urandom_range(0, 11));
      redir = (k1 == 1) || (k1 == 2 && 1'($urandom));
      tgt = {PW'($urandom_range(0, 255)), 2'b00} & PW'(32'hFFFF_FFFC);
      step();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule